// File: doc/BRIEF.md
# Multi-Stream Synchronized Start Gate

This block decides, for each of up to eight DMA stream engines, whether that engine may move data over the serial link. A 32-bit control word holds one hold-off bit per stream. While a stream's hold-off bit is set, the stream is kept off the link even when its engine is running. Software can set the hold-off bits for a group of streams, start their engines, and wait until every held stream reports a filled FIFO. It then clears the bits with one write. The streams released by that write all start on the same later frame boundary.

A stream whose hold-off bit is already zero when its engine starts simply begins at the next frame boundary. A stream stops at once when its hold-off bit is set or when its engine stops. A later start always waits for a fresh frame boundary. A registered status output reports whether every held stream is FIFO-ready. The default build has six streams: bits 0 to 3 are input streams 1 to 4, and bits 4 and 5 are output streams 1 and 2.

Top module: `stream_sync_gate`

## Requirements
- R1: After reset the control word reads 00000000h, every stream enable is 0 and group_ready is 1.
- R2: A read returns the eight stored hold-off bits in bits 7:0 and zero in bits 31:8, even after a write that carried ones in bits 31:8.
- R3: A write changes the hold-off bits only when byte-enable bit 0 is 1. A write with byte-enable bit 0 at 0 leaves every bit unchanged.
- R4: A stream's enable is 0 in the cycle after the clock edge that stores a 1 in its hold-off bit, whatever its RUN input is.
- R5: Streams whose hold-off bits are cleared by one write become enabled together, on the first frame_start pulse sampled on a later clock edge than the write. A frame_start pulse that coincides with the clearing write does not release them.
- R6: A stream whose hold-off bit is 0 and whose RUN rises becomes enabled at the edge where frame_start is next sampled high, and not before.
- R7: When RUN is 0 at a clock edge, that stream's enable is 0 after that edge, with no wait for a frame. When RUN returns to 1, the enable stays 0 until the next frame_start pulse.
- R8: group_ready is registered. After each edge it is 1 exactly when every present stream whose hold-off bit was set before that edge had its FIFO-ready input at 1 at that edge.
- R9: Hold-off bits at positions NUM_STREAMS and above (bits 6 and 7 in the default build) are stored and read back. They affect no stream enable and do not affect group_ready.
- R10: Hold-off bit i gates only stream_en[i]. With six streams, bits 0 to 3 gate input streams 1 to 4 and bits 4 and 5 gate output streams 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte enables of the write; only lane 0 is used |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| run | input | NUM_STREAMS | Per-stream engine RUN flag |
| fifo_rdy | input | NUM_STREAMS | Per-stream FIFO-ready flag |
| frame_start | input | 1 | Single-cycle pulse at the start of each link frame |
| stream_en | output | NUM_STREAMS | Per-stream permission to transfer on the link |
| group_ready | output | 1 | All held streams report FIFO ready |

## Verification
The bench targets the edge where a clearing write and a frame pulse coincide. A design that released on that same frame would start the group in the middle of a frame. It also clears two hold-off bits in one write and checks that both streams rise in the same cycle. A design that released them per bit, or at once, would skew them. Other cases check that dropping RUN stops a stream without waiting for a frame, and that restarting waits for a new frame. They also check that writes without lane 0 are ignored, and that the unused bits 6 and 7 neither gate a stream nor hold group_ready low. An error in any of these shows up as a wrong enable pattern or a wrong read-back value.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  localparam int CTRL_W     = 32;
  localparam int MASK_W     = 8;
  localparam int BE_W       = CTRL_W / 8;
  typedef logic [MASK_W-1:0] hold_mask_t;
endpackage

// File: rtl/ssg_mask_reg.sv
module ssg_mask_reg
  import ssg_pkg::*;
#(
  parameter int W   = CTRL_W,
  parameter int MW  = MASK_W,
  localparam int BW = W / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_be,
  input  logic [W-1:0]  wr_data,
  output logic [MW-1:0] hold_q,
  output logic [MW-1:0] hold_nxt,
  output logic [W-1:0]  rd_data
);
  // only lane 0 carries hold-off bits; remaining lanes are reserved
  logic unused_lanes;
  assign unused_lanes = ^{wr_be[BW-1:1], wr_data[W-1:MW]};

  always_comb begin
    hold_nxt = hold_q;
    if (wr_en && wr_be[0]) hold_nxt = wr_data[MW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= hold_nxt;
  end

  assign rd_data = {{(W-MW){1'b0}}, hold_q};

  AST_LANE0_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_be[0]) |=> $stable(hold_q)); // R3
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[W-1:MW] == '0)); // R2
endmodule

// File: rtl/ssg_gate_cell.sv
module ssg_gate_cell (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hold_q,
  input  logic hold_nxt,
  input  logic frame_start,
  output logic en
);
  logic blocked;
  assign blocked = hold_q | hold_nxt;

  always_ff @(posedge clk) begin
    if (rst)                        en <= 1'b0;
    else if (blocked || !run)       en <= 1'b0;
    else if (frame_start)           en <= 1'b1;
  end

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> !en); // R4
  AST_RUN_STOP: assert property (@(posedge clk) disable iff (rst)
    !run |=> !en); // R7
  AST_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    !en ##1 en |-> $past(frame_start)); // R5
endmodule

// File: rtl/ssg_ready_track.sv
module ssg_ready_track #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hold_q,
  input  logic [N-1:0] fifo_rdy,
  output logic         group_ready
);
  logic [N-1:0] lagging;
  assign lagging = hold_q & ~fifo_rdy;

  always_ff @(posedge clk) begin
    if (rst) group_ready <= 1'b1;
    else     group_ready <= (lagging == '0);
  end

  AST_READY_LOW: assert property (@(posedge clk) disable iff (rst)
    (|(hold_q & ~fifo_rdy)) |=> !group_ready); // R8
  AST_READY_FREE: assert property (@(posedge clk) disable iff (rst)
    (hold_q == '0) |=> group_ready); // R8
endmodule

// File: rtl/stream_sync_gate.sv
module stream_sync_gate
  import ssg_pkg::*;
#(
  parameter int NUM_STREAMS = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [BE_W-1:0]        wr_be,
  input  logic [CTRL_W-1:0]      wr_data,
  output logic [CTRL_W-1:0]      rd_data,
  input  logic [NUM_STREAMS-1:0] run,
  input  logic [NUM_STREAMS-1:0] fifo_rdy,
  input  logic                   frame_start,
  output logic [NUM_STREAMS-1:0] stream_en,
  output logic                   group_ready
);
  hold_mask_t hold_q, hold_nxt;

  ssg_mask_reg #(.W(CTRL_W), .MW(MASK_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .hold_q(hold_q), .hold_nxt(hold_nxt), .rd_data(rd_data)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    ssg_gate_cell u_cell (
      .clk(clk), .rst(rst), .run(run[s]),
      .hold_q(hold_q[s]), .hold_nxt(hold_nxt[s]),
      .frame_start(frame_start), .en(stream_en[s])
    );
  end

  if (NUM_STREAMS < MASK_W) begin : g_spare
    logic unused_spare_next;
    assign unused_spare_next = ^hold_nxt[MASK_W-1:NUM_STREAMS];
  end

  ssg_ready_track #(.N(NUM_STREAMS)) u_ready (
    .clk(clk), .rst(rst), .hold_q(hold_q[NUM_STREAMS-1:0]),
    .fifo_rdy(fifo_rdy), .group_ready(group_ready)
  );

  AST_EN_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (stream_en & ~$past(run)) == '0); // R7
  AST_GROUP_FREE_SPARE: assert property (@(posedge clk) disable iff (rst)
    (hold_q[NUM_STREAMS-1:0] == '0) |=> group_ready); // R9
endmodule

// File: tb/tb_stream_sync_gate.sv
module tb_stream_sync_gate;
  localparam int NS = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [3:0]    wr_be;
  logic [31:0]   wr_data;
  logic [31:0]   rd_data;
  logic [NS-1:0] run, fifo_rdy, stream_en;
  logic          frame_start, group_ready;

  always #2.5 clk = ~clk;

  stream_sync_gate #(.NUM_STREAMS(NS)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .run(run), .fifo_rdy(fifo_rdy),
    .frame_start(frame_start), .stream_en(stream_en), .group_ready(group_ready)
  );

  typedef struct {
    logic [NS-1:0] en;
    logic          gr;
    logic [31:0]   rd;
    string         req;
  } exp_t;

  exp_t exp_q[$];
  int   compared = 0;
  int   mismatched = 0;
  bit   done = 0;

  // monitor: pops one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      compared++;
      if (stream_en !== e.en || group_ready !== e.gr || rd_data !== e.rd) begin
        mismatched++;
        $display("FAIL %s: got en=%h gr=%b rd=%h, expected en=%h gr=%b rd=%h",
                 e.req, stream_en, group_ready, rd_data, e.en, e.gr, e.rd);
      end
    end
  end

  // driver: applies one cycle of stimulus and queues the result of that edge
  task automatic step(input logic we, input logic [3:0] be, input logic [31:0] d,
                      input logic [NS-1:0] r, input logic [NS-1:0] f, input logic fs,
                      input logic [NS-1:0] xen, input logic xgr, input logic [31:0] xrd,
                      input string req);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_be = be; wr_data = d; run = r; fifo_rdy = f; frame_start = fs;
    @(posedge clk);
    #1;
    e.en = xen; e.gr = xgr; e.rd = xrd; e.req = req;
    exp_q.push_back(e);
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; wr_be = 0; wr_data = 0; run = 0; fifo_rdy = 0; frame_start = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    //    we be  data        run  fifo fs  en   gr  rd
    step(0, 4'h0, 32'h0,      6'h00, 6'h00, 0, 6'h00, 1, 32'h00, "R1 reset state");
    step(1, 4'hF, 32'hFFFFFF3F, 6'h00, 6'h00, 0, 6'h00, 1, 32'h3F, "R2 reserved bits read zero");
    step(0, 4'h0, 32'h0,      6'h3F, 6'h00, 1, 6'h00, 0, 32'h3F, "R4 held streams blocked / R8");
    step(0, 4'h0, 32'h0,      6'h3F, 6'h0F, 0, 6'h00, 0, 32'h3F, "R8 partial fifo ready");
    step(0, 4'h0, 32'h0,      6'h3F, 6'h3F, 0, 6'h00, 1, 32'h3F, "R8 all fifo ready");
    step(1, 4'hE, 32'h0,      6'h3F, 6'h3F, 0, 6'h00, 1, 32'h3F, "R3 lane0 disabled write ignored");
    step(1, 4'h1, 32'h0,      6'h3F, 6'h3F, 1, 6'h00, 1, 32'h00, "R5 coincident frame no release");
    step(0, 4'h0, 32'h0,      6'h3F, 6'h3F, 0, 6'h00, 1, 32'h00, "R5 wait for frame");
    step(0, 4'h0, 32'h0,      6'h3F, 6'h3F, 1, 6'h3F, 1, 32'h00, "R5 group release together");
    step(1, 4'h1, 32'h05,     6'h3F, 6'h3F, 0, 6'h3A, 1, 32'h05, "R4 set bits drop enable");
    step(0, 4'h0, 32'h0,      6'h32, 6'h3F, 0, 6'h32, 1, 32'h05, "R7 run clear drops at once");
    step(0, 4'h0, 32'h0,      6'h3A, 6'h3F, 0, 6'h32, 1, 32'h05, "R7 restart waits for frame");
    step(0, 4'h0, 32'h0,      6'h3A, 6'h3F, 1, 6'h3A, 1, 32'h05, "R7 restart on frame");
    step(1, 4'h1, 32'hC5,     6'h3A, 6'h3F, 0, 6'h3A, 1, 32'hC5, "R9 spare bits stored");
    step(1, 4'h1, 32'hC0,     6'h3F, 6'h3F, 0, 6'h3A, 1, 32'hC0, "R5 multi-bit clear, no frame");
    step(0, 4'h0, 32'h0,      6'h3F, 6'h00, 0, 6'h3A, 1, 32'hC0, "R9 spare bits ignored by ready");
    step(0, 4'h0, 32'h0,      6'h3F, 6'h00, 1, 6'h3F, 1, 32'hC0, "R5 R10 streams 0 and 2 rise together");
    step(1, 4'h1, 32'h00,     6'h00, 6'h00, 0, 6'h00, 1, 32'h00, "R7 run cleared for all");
    step(0, 4'h0, 32'h0,      6'h10, 6'h00, 0, 6'h00, 1, 32'h00, "R6 free start waits frame");
    step(0, 4'h0, 32'h0,      6'h10, 6'h00, 1, 6'h10, 1, 32'h00, "R6 R10 free start on frame");
    step(1, 4'h1, 32'h01,     6'h11, 6'h00, 1, 6'h10, 1, 32'h01, "R10 bit0 gates only stream 0");
    step(0, 4'h0, 32'h0,      6'h11, 6'h00, 0, 6'h10, 0, 32'h01, "R8 held stream 0 not ready");
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout after %0d cycles, expected completion", cycles);
    end
    if (exp_q.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL scoreboard: got %0d unconsumed items, expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule